// File: doc/BRIEF.md
# Precharged Manchester Carry Chain

This block is a clock-cycle model of a dynamic carry chain that runs in two phases. A phase input chooses the mode. While the phase is low the chain precharges, and every internal carry node returns to its high level. While the phase is high the chain evaluates. Each bit forms generate (A AND B), propagate (A XOR B) and delete (neither operand set). A node can only discharge, and it does so when its bit generates, or when its bit propagates while the carry into it is present. The nodes therefore hold inverted carries, and static inverters turn them into the true carry outputs.

The sum bits and the final carry-out are captured on the clock edge that ends an evaluate phase. They then stay unchanged for the whole of the following precharge. The chain only works if its inputs are monotonic: operands and carry-in must be zero during precharge, and during evaluate the generate, propagate and carry-in signals may rise but never fall. A sticky flag records any break of these rules, so that sequencing errors in the surrounding logic can be seen.

Top module: `manchester_chain`

## Requirements
- R1: On a clock edge where `phase` is 0, every carry node precharges, so `carry` reads all zeros after that edge.
- R2: On a clock edge where `phase` is 1 and the inputs are legal, `carry[i]` becomes the carry out of bit i of A+B+Cin. Generate is A AND B, propagate is A XOR B, and bit i receives `cin` when i is 0 and the carry out of bit i-1 otherwise.
- R3: A carry bit that has been set stays set on every later evaluate edge, even if the inputs fall, until the next precharge edge.
- R4: On the first precharge edge after an evaluate phase, `sum` takes the value (A XOR B XOR carry-in per bit) of the last evaluate inputs and `cout` takes the last carry, `carry[W-1]`. For legal inputs these are the low W bits and bit W of A+B+Cin.
- R5: `sum` and `cout` do not change across an edge where `phase` is 0 and was already 0 on the previous edge.
- R6: `viol` is set if `phase` is 0 on an edge while `a`, `b` or `cin` is nonzero.
- R7: `viol` is set if, on two consecutive evaluate edges, any generate bit, propagate bit or `cin` goes from 1 to 0.
- R8: `viol` stays set until reset. Rising transitions during evaluate do not set it.
- R9: While `rst_n` is low, `carry`, `sum`, `cout` and `viol` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 1 | 0 = precharge, 1 = evaluate |
| a | input | W | Operand A |
| b | input | W | Operand B |
| cin | input | 1 | Carry into bit 0 |
| carry | output | W | True carries, inverted from the dynamic nodes |
| sum | output | W | Sum captured at the end of evaluate |
| cout | output | 1 | Carry-out captured at the end of evaluate |
| viol | output | 1 | Sticky monotonicity violation flag |

## Verification
The bench builds the chain with W = 4. At that width the operand and carry-in space has only 512 points, so every point is run through a full precharge, evaluate and capture sequence and compared against integer addition. The small width also makes it practical to check each single-bit transition directly. These include a carry-in that rises in the middle of an evaluate phase, an operand that falls after a node has already discharged, and nonzero inputs during precharge, each of which the reference model follows edge by edge.

// File: rtl/manchester_chain.sv
module manchester_chain #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phase,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] carry,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         viol
);

  logic [W-1:0] gen, prop, drop, node_q;
  logic [W-1:0] gen_q, prop_q, sum_q;
  logic         cin_q, phase_q, cout_q, viol_q;
  logic         bad;

  assign gen  = a & b;
  assign prop = a ^ b;

  always_comb begin
    logic c;
    c = cin;
    for (int i = 0; i < W; i++) begin
      drop[i] = gen[i] | (prop[i] & c);
      c = drop[i] | ~node_q[i];
    end
  end

  assign bad = phase ? (phase_q && (|(gen_q & ~gen) || |(prop_q & ~prop) || (cin_q & ~cin)))
                     : (|a || |b || cin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_q  <= '1;
      gen_q   <= '0;
      prop_q  <= '0;
      cin_q   <= 1'b0;
      phase_q <= 1'b0;
      sum_q   <= '0;
      cout_q  <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      if (phase_q && !phase) begin
        sum_q  <= prop_q ^ {~node_q[W-2:0], cin_q};
        cout_q <= ~node_q[W-1];
      end
      node_q  <= phase ? (node_q & ~drop) : '1;
      gen_q   <= gen;
      prop_q  <= prop;
      cin_q   <= cin;
      phase_q <= phase;
      viol_q  <= viol_q | bad;
    end
  end

  assign carry = ~node_q;
  assign sum   = sum_q;
  assign cout  = cout_q;
  assign viol  = viol_q;

endmodule

module chain_checks #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         phase,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] carry,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic         viol
);

  AST_PRECHARGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> carry == '0); // R1

  AST_NODE_NO_RECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase |=> ((carry & $past(carry)) == $past(carry))); // R3

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && !$past(phase)) |=> ($stable(sum) && $stable(cout))); // R5

  AST_PRECHARGE_INPUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && (a != '0 || b != '0 || cin)) |=> viol); // R6

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (!rst_n -> (carry == '0 && sum == '0 && !cout && !viol))); // R9

endmodule

bind manchester_chain chain_checks #(.W(W)) u_chk (.*);

// File: tb/sim_manchester_chain.sv
module sim_manchester_chain;
  localparam int W   = 4;
  localparam int PER = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         phase = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] carry, sum;
  logic         cout, viol;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_acc, m_sum, m_pg, m_pp;
  logic         m_cout, m_viol, m_pc, m_pph;

  always #(PER/2) clk = ~clk;

  manchester_chain #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .phase(phase), .a(a), .b(b), .cin(cin),
    .carry(carry), .sum(sum), .cout(cout), .viol(viol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_sum = '0; m_cout = 0; m_viol = 0;
    m_pg = '0; m_pp = '0; m_pc = 0; m_pph = 0;
  endtask

  task automatic model_edge(input logic ph, input logic [W-1:0] ea, eb, input logic ec);
    logic [W-1:0] g, p;
    logic bad, c;
    g = ea & eb;
    p = ea ^ eb;
    if (!ph) bad = (ea != 0) || (eb != 0) || ec;
    else bad = m_pph && (((m_pg & ~g) != 0) || ((m_pp & ~p) != 0) || (m_pc && !ec));
    m_viol = m_viol | bad;
    if (m_pph && !ph) begin
      m_sum  = m_pp ^ {m_acc[W-2:0], m_pc};
      m_cout = m_acc[W-1];
    end
    if (!ph) m_acc = '0;
    else begin
      c = ec;
      for (int i = 0; i < W; i++) begin
        m_acc[i] = m_acc[i] | g[i] | (p[i] & c);
        c = m_acc[i];
      end
    end
    m_pg = g; m_pp = p; m_pc = ec; m_pph = ph;
  endtask

  task automatic compare_all();
    chk("R1/R2/R3 carry", 32'(carry), 32'(m_acc));
    chk("R4/R5 sum", 32'(sum), 32'(m_sum));
    chk("R4/R5 cout", 32'(cout), 32'(m_cout));
    chk("R6/R7/R8 viol", 32'(viol), 32'(m_viol));
  endtask

  task automatic cyc(input logic ph, input logic [W-1:0] ea, eb, input logic ec);
    phase = ph; a = ea; b = eb; cin = ec;
    @(posedge clk);
    model_edge(ph, ea, eb, ec);
    #(PER/4);
    compare_all();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; phase = 0; a = '0; b = '0; cin = 0;
    repeat (2) @(posedge clk);
    model_reset();
    #(PER/4);
    chk("R9 carry", 32'(carry), 0);
    chk("R9 sum", 32'(sum), 0);
    chk("R9 cout", 32'(cout), 0);
    chk("R9 viol", 32'(viol), 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    for (int v = 0; v < (1 << (2*W+1)); v++) begin
      logic [W-1:0] va, vb;
      logic vc;
      int total;
      va = v[W-1:0]; vb = v[2*W-1:W]; vc = v[2*W];
      total = int'(va) + int'(vb) + int'(vc);
      cyc(0, '0, '0, 0);
      cyc(1, va, vb, vc);
      for (int i = 0; i < W; i++) begin
        int msk;
        msk = (1 << (i+1)) - 1;
        chk("R2 carry bit", 32'(carry[i]),
            32'((((int'(va) & msk) + (int'(vb) & msk) + int'(vc)) >> (i+1)) & 1));
      end
      cyc(0, '0, '0, 0);
      chk("R4 sum vs A+B+Cin", 32'(sum), 32'(total & ((1 << W) - 1)));
      chk("R4 cout vs A+B+Cin", 32'(cout), 32'((total >> W) & 1));
      cyc(0, '0, '0, 0);
      chk("R5 sum held", 32'(sum), 32'(total & ((1 << W) - 1)));
    end
    chk("R8 no violation on legal run", 32'(viol), 0);

    cyc(1, 4'b0111, 4'b1000, 0);
    chk("R8 carry before cin rise", 32'(carry), 0);
    cyc(1, 4'b0111, 4'b1000, 1);
    chk("R8 carry after cin rise", 32'(carry), 32'(4'b1111));
    chk("R8 rising cin is legal", 32'(viol), 0);
    cyc(0, '0, '0, 0);
    chk("R4 sum after late cin", 32'(sum), 0);
    chk("R4 cout after late cin", 32'(cout), 1);

    cyc(1, 4'b0001, 4'b0001, 0);
    cyc(1, 4'b0000, 4'b0000, 0);
    chk("R3 carry held after fall", 32'(carry), 32'(4'b0001));
    chk("R7 falling generate flagged", 32'(viol), 1);
    cyc(0, '0, '0, 0);
    chk("R8 flag sticky", 32'(viol), 1);

    do_reset();
    cyc(0, 4'b0010, '0, 0);
    chk("R6 nonzero in precharge", 32'(viol), 1);
    cyc(0, '0, '0, 0);
    chk("R1 precharged carries", 32'(carry), 0);

    do_reset();
    cyc(1, '0, '0, 1);
    cyc(1, '0, '0, 0);
    chk("R7 falling cin flagged", 32'(viol), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule